// File: doc/BRIEF.md
# Packed-Opcode 16-bit Stack Processor

This block is a compact zero-operand processor for control tasks next to a single synchronous memory. Every 16-bit word it fetches is one of two things. It is either a subroutine call carrying its own target address, or a bundle of four 4-bit operations. The operations of a bundle run back to back, one per clock, so one fetch feeds four operations.

All operands live on an on-chip data stack. Return addresses live on a separate on-chip return stack. Both stacks are sixteen entries deep. Inline literals and branch targets sit in the words that follow the bundle using them.

The core drives one single-port memory through an address, write data and write enable. Read data comes back one cycle after the address. A single status output reports that either stack has been pushed past full or popped past empty.

Top module: `nsc_core`

## Requirements
- R1: While reset is held, mem_addr is 0, mem_we is 0 and stack_err is 0. After release, the first word is fetched from address 0.
- R2: A word with bit 15 clear is a call. The program counter becomes {0, word[14:0]}, and the address of the word after the call is pushed on the return stack. A word with bit 15 set carries four opcodes. They run in the order bits [15:12], [11:8], [7:4], [3:0], and the next word is fetched after the fourth.
- R3: Opcode values: 0, 14 and 15 nop; 1 add; 2 sub; 3 and; 4 xor; 5 dup; 6 drop; 7 swap; 8 over; 9 literal; 10 load; 11 store; 12 return; 13 branch-if-zero. Because bit 15 is set, the first slot can only hold opcodes 8 to 15.
- R4: The add, sub, and, and xor opcodes pop top T and next N, then push N+T, N-T, N&T or N^T respectively, modulo 2^16.
- R5: dup pushes a copy of T. drop discards T. swap exchanges T and N. over pushes a copy of N.
- R6: literal pushes the memory word at the program counter and advances the program counter past it. Several literals in one word consume successive following words.
- R7: load replaces T with memory[T]. store writes N to memory[T] and pops both.
- R8: return pops the return stack into the program counter and discards the remaining slots of the current word.
- R9: branch-if-zero pops T and reads the next inline word as a target. If T was 0, it jumps there and discards the remaining slots. Otherwise it skips the target word and continues with the next slot.
- R10: Stack-only opcodes take one cycle each. literal, load and branch-if-zero take two cycles. A word fetch takes two cycles. A bundle of literal, dup, dup, add followed by a bundle starting literal, store writes memory in the 12th cycle after reset release.
- R11: Pushing onto a full stack or popping below empty wraps the stack pointer and sets stack_err. stack_err then stays 1 until reset.
- R12: mem_we is high only during the single cycle of a store opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address for fetch, literal, load and store |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| stack_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
Every read completes in the cycle after its address. So a literal's value is on the stack two cycles after the slot starts. A fetched word is decoded one cycle after its fetch, and a store lands in the external memory at the edge that ends its slot.

The bench does not sample the stacks mid-flight. Each program ends in a balanced idle loop, and memory contents and stack_err are checked only after a fixed margin of cycles. The one timing case counts clock edges from reset release to the first write strobe and expects exactly eleven.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_XOR   = 4'd4,
        OP_DUP   = 4'd5,
        OP_DROP  = 4'd6,
        OP_SWAP  = 4'd7,
        OP_OVER  = 4'd8,
        OP_LIT   = 4'd9,
        OP_LOAD  = 4'd10,
        OP_STORE = 4'd11,
        OP_RET   = 4'd12,
        OP_BZ    = 4'd13,
        OP_NOPB  = 4'd14,
        OP_NOPC  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WAIT
    } seq_st_e;

    typedef enum logic [1:0] {
        MV_HOLD,
        MV_PUSH,
        MV_POP,
        MV_POP2
    } move_e;

endpackage

// File: rtl/nsc_alu.sv
module nsc_alu
    import nsc_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] nos,
    input  logic [W-1:0] tos,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            OP_ADD:  y = nos + tos;
            OP_SUB:  y = nos - tos;
            OP_AND:  y = nos & tos;
            OP_XOR:  y = nos ^ tos;
            default: y = tos;
        endcase
    end
endmodule

// File: rtl/nsc_lifo.sv
module nsc_lifo
    import nsc_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  move_e        mv,
    input  logic         wr_top,
    input  logic [W-1:0] top_in,
    input  logic         wr_sec,
    input  logic [W-1:0] sec_in,
    output logic [W-1:0] top,
    output logic [W-1:0] sec,
    output logic         err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          err;
    } lifo_s;

    lifo_s         q, d;
    logic [W-1:0]  cells [DEPTH];
    logic [AW-1:0] below_d;

    always_comb begin
        d = q;
        case (mv)
            MV_PUSH: begin
                d.ptr = q.ptr + AW'(1);
                if (q.cnt == FULL) d.err = 1'b1;
                else               d.cnt = q.cnt + CW'(1);
            end
            MV_POP: begin
                d.ptr = q.ptr - AW'(1);
                if (q.cnt == '0) d.err = 1'b1;
                else             d.cnt = q.cnt - CW'(1);
            end
            MV_POP2: begin
                d.ptr = q.ptr - AW'(2);
                if (q.cnt < CW'(2)) begin
                    d.err = 1'b1;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt - CW'(2);
                end
            end
            default: ;
        endcase
        below_d = d.ptr - AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ptr <= '1;
            q.cnt <= '0;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_top && d.ptr == AW'(i))
                cells[i] <= top_in;
            else if (wr_sec && below_d == AW'(i))
                cells[i] <= sec_in;
        end
    end

    assign top = cells[q.ptr];
    assign sec = cells[q.ptr - AW'(1)];
    assign err = q.err;
endmodule

// File: rtl/nsc_seq.sv
module nsc_seq
    import nsc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic         mem_we,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic [W-1:0] ds_top,
    input  logic [W-1:0] ds_sec,
    input  logic [W-1:0] rs_top,
    input  logic [W-1:0] alu_y,
    output move_e        ds_mv,
    output logic         ds_wt,
    output logic [W-1:0] ds_tv,
    output logic         ds_ws,
    output logic [W-1:0] ds_sv,
    output move_e        rs_mv,
    output logic         rs_wt,
    output logic [W-1:0] rs_tv,
    output seq_st_e      st,
    output op_e          cur_op
);
    localparam int NSLOT = W / 4;
    localparam int SW    = $clog2(NSLOT);
    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    typedef struct packed {
        logic [W-1:0]  pc;
        logic [W-1:0]  ir;
        logic [SW-1:0] slot;
        seq_st_e       st;
        logic          zf;
    } seq_s;

    seq_s q, d;
    logic adv;
    op_e  op;

    always_comb begin
        op = op_e'(q.ir[4*(NSLOT-1-int'(q.slot)) +: 4]);
    end

    always_comb begin
        d         = q;
        adv       = 1'b0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        ds_mv     = MV_HOLD;
        ds_wt     = 1'b0;
        ds_tv     = '0;
        ds_ws     = 1'b0;
        ds_sv     = '0;
        rs_mv     = MV_HOLD;
        rs_wt     = 1'b0;
        rs_tv     = '0;
        case (q.st)
            ST_FETCH: begin
                mem_addr = q.pc;
                d.pc     = q.pc + W'(1);
                d.st     = ST_DECODE;
            end
            ST_DECODE: begin
                if (!mem_rdata[W-1]) begin
                    rs_mv = MV_PUSH;
                    rs_wt = 1'b1;
                    rs_tv = q.pc;
                    d.pc  = {1'b0, mem_rdata[W-2:0]};
                    d.st  = ST_FETCH;
                end else begin
                    d.ir   = mem_rdata;
                    d.slot = '0;
                    d.st   = ST_EXEC;
                end
            end
            ST_EXEC: begin
                adv = 1'b1;
                case (op)
                    OP_ADD, OP_SUB, OP_AND, OP_XOR: begin
                        ds_mv = MV_POP;
                        ds_wt = 1'b1;
                        ds_tv = alu_y;
                    end
                    OP_DUP: begin
                        ds_mv = MV_PUSH;
                        ds_wt = 1'b1;
                        ds_tv = ds_top;
                    end
                    OP_DROP: ds_mv = MV_POP;
                    OP_SWAP: begin
                        ds_wt = 1'b1;
                        ds_tv = ds_sec;
                        ds_ws = 1'b1;
                        ds_sv = ds_top;
                    end
                    OP_OVER: begin
                        ds_mv = MV_PUSH;
                        ds_wt = 1'b1;
                        ds_tv = ds_sec;
                    end
                    OP_LIT: begin
                        mem_addr = q.pc;
                        d.pc     = q.pc + W'(1);
                        d.st     = ST_WAIT;
                        adv      = 1'b0;
                    end
                    OP_LOAD: begin
                        mem_addr = ds_top;
                        d.st     = ST_WAIT;
                        adv      = 1'b0;
                    end
                    OP_STORE: begin
                        mem_addr  = ds_top;
                        mem_wdata = ds_sec;
                        mem_we    = 1'b1;
                        ds_mv     = MV_POP2;
                    end
                    OP_RET: begin
                        d.pc  = rs_top;
                        rs_mv = MV_POP;
                        d.st  = ST_FETCH;
                        adv   = 1'b0;
                    end
                    OP_BZ: begin
                        mem_addr = q.pc;
                        d.pc     = q.pc + W'(1);
                        d.zf     = (ds_top == '0);
                        ds_mv    = MV_POP;
                        d.st     = ST_WAIT;
                        adv      = 1'b0;
                    end
                    default: ;
                endcase
            end
            ST_WAIT: begin
                adv = 1'b1;
                case (op)
                    OP_LIT: begin
                        ds_mv = MV_PUSH;
                        ds_wt = 1'b1;
                        ds_tv = mem_rdata;
                    end
                    OP_LOAD: begin
                        ds_wt = 1'b1;
                        ds_tv = mem_rdata;
                    end
                    OP_BZ: begin
                        if (q.zf) begin
                            d.pc = mem_rdata;
                            d.st = ST_FETCH;
                            adv  = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            default: d.st = ST_FETCH;
        endcase
        if (adv) begin
            if (q.slot == LAST) begin
                d.st = ST_FETCH;
            end else begin
                d.slot = q.slot + SW'(1);
                d.st   = ST_EXEC;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pc   <= '0;
            q.ir   <= '0;
            q.slot <= '0;
            q.st   <= ST_FETCH;
            q.zf   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign st     = q.st;
    assign cur_op = op;
endmodule

// File: rtl/nsc_core.sv
module nsc_core
    import nsc_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic         mem_we,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         stack_err
);
    logic [W-1:0] ds_top, ds_sec, rs_top, rs_sec, alu_y;
    logic [W-1:0] ds_tv, ds_sv, rs_tv;
    logic         ds_wt, ds_ws, rs_wt, ds_err, rs_err;
    move_e        ds_mv, rs_mv;
    seq_st_e      seq_st;
    op_e          seq_op;

    nsc_seq #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .ds_top(ds_top), .ds_sec(ds_sec), .rs_top(rs_top), .alu_y(alu_y),
        .ds_mv(ds_mv), .ds_wt(ds_wt), .ds_tv(ds_tv), .ds_ws(ds_ws), .ds_sv(ds_sv),
        .rs_mv(rs_mv), .rs_wt(rs_wt), .rs_tv(rs_tv),
        .st(seq_st), .cur_op(seq_op)
    );

    nsc_alu #(.W(W)) u_alu (
        .op(seq_op), .nos(ds_sec), .tos(ds_top), .y(alu_y)
    );

    nsc_lifo #(.W(W), .DEPTH(DEPTH)) u_dstk (
        .clk(clk), .rst_n(rst_n), .mv(ds_mv),
        .wr_top(ds_wt), .top_in(ds_tv), .wr_sec(ds_ws), .sec_in(ds_sv),
        .top(ds_top), .sec(ds_sec), .err(ds_err)
    );

    nsc_lifo #(.W(W), .DEPTH(DEPTH)) u_rstk (
        .clk(clk), .rst_n(rst_n), .mv(rs_mv),
        .wr_top(rs_wt), .top_in(rs_tv), .wr_sec(1'b0), .sec_in('0),
        .top(rs_top), .sec(rs_sec), .err(rs_err)
    );

    assign stack_err = ds_err | rs_err;
endmodule

// File: rtl/nsc_core_chk.sv
module nsc_core_chk
    import nsc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] mem_addr,
    input logic         mem_we,
    input logic [W-1:0] mem_rdata,
    input logic         stack_err,
    input seq_st_e      seq_st,
    input op_e          seq_op
);
    // R10
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_st == ST_FETCH |=> seq_st == ST_DECODE);

    // R10
    single_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_st == ST_WAIT |=> seq_st != ST_WAIT);

    // R2
    call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_DECODE && !mem_rdata[W-1]) |=>
        (seq_st == ST_FETCH && mem_addr == {1'b0, $past(mem_rdata[W-2:0])}));

    // R8
    ret_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_EXEC && seq_op == OP_RET) |=> seq_st == ST_FETCH);

    // R11
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

    // R12
    write_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (seq_st == ST_EXEC && seq_op == OP_STORE));
endmodule

bind nsc_core nsc_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .stack_err(stack_err),
    .seq_st(seq_st), .seq_op(seq_op)
);

// File: tb/nsc_core_test.sv
module nsc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, stack_err;
    logic [15:0] ram [256];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam logic [15:0] HALT = 16'h9DEE;

    always #5 clk = ~clk;

    nsc_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .stack_err(stack_err)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[7:0]];
    end

    function automatic logic [15:0] exp_alu(int op, logic [15:0] n, logic [15:0] t);
        case (op)
            1: return n + t;
            2: return n - t;
            3: return n & t;
            default: return n ^ t;
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 256; i++) ram[i] = 16'h0;
    endtask

    task automatic put_halt(int at);
        ram[at]   = HALT;
        ram[at+1] = 16'h0;
        ram[at+2] = 16'(at);
    endtask

    task automatic go(int cyc);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (cyc) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, b, c;
        int op;
        void'($urandom(32'd2024));

        // R1 reset state
        hold_reset();
        #1;
        chk(mem_addr == 16'h0, "R1 addr", mem_addr, 16'h0);
        chk(mem_we == 1'b0, "R1 we", {15'h0, mem_we}, 16'h0);
        chk(stack_err == 1'b0, "R1 err", {15'h0, stack_err}, 16'h0);

        // R4 R3 random arithmetic and logic
        for (int k = 0; k < 16; k++) begin
            a = 16'($urandom); b = 16'($urandom);
            op = 1 + (k % 4);
            if (k == 0) begin a = 16'hFFFF; b = 16'h0001; end
            if (k == 1) begin a = 16'h0000; b = 16'h0001; end
            hold_reset();
            ram[0] = 16'h9909 | 16'(op << 4);
            ram[1] = a; ram[2] = b; ram[3] = 16'h0080;
            ram[4] = 16'hBEEE;
            put_halt(5);
            go(40);
            chk(ram[8'h80] == exp_alu(op, a, b), "R4 alu", ram[8'h80], exp_alu(op, a, b));
            chk(stack_err == 1'b0, "R4 err", {15'h0, stack_err}, 16'h0);
        end

        // R5 swap and drop, R6 successive literals
        a = 16'($urandom); b = 16'($urandom); c = 16'($urandom);
        hold_reset();
        ram[0] = 16'h9979; ram[1] = a; ram[2] = b; ram[3] = 16'h0081;
        ram[4] = 16'hB969; ram[5] = c; ram[6] = 16'h0082;
        ram[7] = 16'hBEEE;
        put_halt(8);
        go(60);
        chk(ram[8'h81] == a, "R5 swap", ram[8'h81], a);
        chk(ram[8'h82] == b, "R5 drop", ram[8'h82], b);

        // R5 over and dup
        hold_reset();
        ram[0] = 16'h9989; ram[1] = a; ram[2] = b; ram[3] = 16'h0083;
        ram[4] = 16'hB9B5; ram[5] = 16'h0084;
        ram[6] = 16'hE19B; ram[7] = 16'h0085;
        put_halt(8);
        go(60);
        chk(ram[8'h83] == a, "R5 over", ram[8'h83], a);
        chk(ram[8'h84] == b, "R5 over keeps", ram[8'h84], b);
        chk(ram[8'h85] == 16'(a + a), "R5 dup", ram[8'h85], 16'(a + a));

        // R2 R8 call and return discarding remaining slots
        hold_reset();
        ram[0] = 16'h0010; ram[1] = 16'h9BEE; ram[2] = 16'h0086;
        put_halt(3);
        ram[8'h10] = 16'h9C99; ram[8'h11] = c;
        go(60);
        chk(ram[8'h86] == c, "R8 return", ram[8'h86], c);
        chk(stack_err == 1'b0, "R2 call balance", {15'h0, stack_err}, 16'h0);

        // R9 branch taken and not taken
        for (int t = 0; t < 2; t++) begin
            hold_reset();
            ram[0] = 16'h9D99; ram[1] = 16'(t); ram[2] = 16'h0020;
            ram[3] = 16'h1111; ram[4] = 16'h0087; ram[5] = 16'hBEEE;
            put_halt(6);
            ram[8'h20] = 16'h99BE; ram[8'h21] = 16'h2222; ram[8'h22] = 16'h0087;
            put_halt(8'h23);
            go(60);
            if (t == 0) chk(ram[8'h87] == 16'h2222, "R9 taken", ram[8'h87], 16'h2222);
            else        chk(ram[8'h87] == 16'h1111, "R9 not taken", ram[8'h87], 16'h1111);
        end

        // R7 load
        hold_reset();
        ram[0] = 16'h9A9B; ram[1] = 16'h0040; ram[2] = 16'h0088;
        put_halt(3);
        ram[8'h40] = b;
        go(40);
        chk(ram[8'h88] == b, "R7 load", ram[8'h88], b);

        // R10 R12 cycle of the first write strobe
        begin
            int cnt = 0;
            bit seen = 1'b0;
            hold_reset();
            ram[0] = 16'h9551; ram[1] = a; ram[2] = 16'h9BEE; ram[3] = 16'h0089;
            put_halt(4);
            @(negedge clk);
            rst_n = 1'b1;
            while (!seen && cnt < 40) begin
                @(posedge clk);
                #1;
                cnt++;
                if (mem_we) seen = 1'b1;
            end
            chk(cnt == 11, "R10 store cycle", 16'(cnt), 16'd11);
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(ram[8'h89] == 16'(a + a), "R12 store data", ram[8'h89], 16'(a + a));
        end

        // R11 underflow
        hold_reset();
        ram[0] = 16'hE6EE;
        put_halt(1);
        go(30);
        chk(stack_err == 1'b1, "R11 underflow", {15'h0, stack_err}, 16'h1);

        // R11 overflow and sticky
        hold_reset();
        for (int w = 0; w < 5; w++) begin
            ram[w*5] = 16'h9999;
            for (int j = 1; j < 5; j++) ram[w*5+j] = 16'(w*4 + j);
        end
        put_halt(25);
        go(80);
        chk(stack_err == 1'b1, "R11 overflow", {15'h0, stack_err}, 16'h1);
        go(40);
        chk(stack_err == 1'b1, "R11 sticky", {15'h0, stack_err}, 16'h1);

        // R1 reset clears the flag
        hold_reset();
        #1;
        chk(stack_err == 1'b0, "R1 err cleared", {15'h0, stack_err}, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule